// File: doc/BRIEF.md
# Segmented Sampling-Cell Write Controller

This block steers writing into one channel's array of analog sampling cells. Each sample clock it raises exactly one cell write enable, and it walks the cells in a circular order. No cell is ever kept unless a trigger asks for it, so older samples are simply overwritten. The array runs in one of two layouts. In ring layout the whole array is one circular buffer. In slotted layout it is cut into equal slots of 32 cells, and between one and eight of them are in use.

On a trigger, the slot being written is frozen and handed to digitization through a one-cycle conversion request. The request carries the slot number and the exact cell that was being written when the trigger came, so readout can put the samples back in time order. Writing then jumps to the first cell of the next free slot. When every slot in use is frozen, writing halts and an overflow flag stays high until digitization hands a slot back.

The layout and slot count are captured only while the run input is low. Changes made during acquisition have no effect.

Top module: `amw_write_ctrl`

## Requirements
- R1: After reset no cell write enable is high, every frozen flag is 0, the conversion request is 0 and overflow is 0.
- R2: While `run_i` is high and writing is not halted, exactly one bit of `cell_we_o` is high in each cycle. While `run_i` is low, none is high, starting in that same cycle. Writing begins one cycle after `run_i` rises.
- R3: In ring layout (`cfg_seg_i`=0 when latched), the written cell index goes up by one each cycle and wraps from 255 to 0 over the whole array.
- R4: In slotted layout (`cfg_seg_i`=1), with slot count n encoded as `cfg_slots_i`=n-1, the cell written is slot*32+offset. The offset goes up by one each cycle and wraps from 31 to 0 inside the active slot.
- R5: A trigger in a writing cycle gives, in the next cycle, `conv_req_o`=1 for that one cycle. In that cycle `conv_slot_o` is the slot that was written, `trig_cell_o` is the cell index that was written in the trigger cycle, and the slot's bit in `frozen_o` is set.
- R6: After a trigger, writing goes on in the very next cycle at offset 0 of the first slot that is not frozen. The search runs in ascending circular order starting after the triggered slot, among slots 0..n-1.
- R7: If no slot is free, no cell is written and `overflow_o` is 1 from the next cycle on. Triggers have no effect while writing is halted: no conversion request is issued.
- R8: A `done_i` pulse with `done_slot_i` clears that slot's frozen flag at the next edge. If writing was halted, it resumes in the cycle after that edge, in the freed slot, and overflow drops to 0.
- R9: Layout and slot count are captured only while `run_i` is low. Changes made while `run_i` is high have no effect on which cells are written or on how many slots are used.
- R10: In ring layout the single slot is number 0, and a trigger freezes the whole array. Writing halts until slot 0 is released, then restarts at cell 0.
- R11: Frozen flags survive `run_i` going low. When `run_i` rises again, writing starts at offset 0 of the lowest-numbered free slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Acquisition enable; configuration is captured while low |
| trig_i | input | 1 | Trigger; freezes the slot being written |
| cfg_seg_i | input | 1 | Layout: 0 ring, 1 slotted |
| cfg_slots_i | input | 3 | Slot count minus one, slotted layout only |
| done_i | input | 1 | Digitization finished for one slot |
| done_slot_i | input | 3 | Slot released by `done_i` |
| cell_we_o | output | 256 | One-hot write enable per sampling cell |
| frozen_o | output | 8 | Per-slot flag: held for digitization |
| conv_req_o | output | 1 | One-cycle conversion request |
| conv_slot_o | output | 3 | Slot to digitize, valid with `conv_req_o` |
| trig_cell_o | output | 8 | Cell written when the trigger arrived |
| overflow_o | output | 1 | Writing halted because no slot is free |

## Verification
A wrong pointer or wrong active slot shows up on `cell_we_o` in the same cycle as a write to the wrong cell. This means one clock of drift is visible right away, and the bench compares the written index every cycle against an arithmetic model. A wrong free-slot choice shows up the cycle after a trigger, because the first write lands at the wrong slot base. Lost or stuck frozen flags show up on `frozen_o` one edge after the trigger or release that should have changed them. They also show up indirectly, as a missing or spurious overflow when the slots fill up. A configuration captured at the wrong time shows up as a wrap at the wrong offset, or as a halt after the wrong number of triggers.

// File: rtl/amw_pkg.sv
package amw_pkg;
  localparam int unsigned DEF_CELLS      = 256;
  localparam int unsigned DEF_SLOT_CELLS = 32;
  localparam int unsigned DEF_SLOTS      = 8;

  typedef enum logic {
    MODE_RING = 1'b0,
    MODE_SEG  = 1'b1
  } mode_e;
endpackage

// File: rtl/amw_cfg_latch.sv
module amw_cfg_latch
  import amw_pkg::*;
#(
  parameter int unsigned SLOTS = DEF_SLOTS
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load_i,
  input  logic                       seg_i,
  input  logic [$clog2(SLOTS)-1:0]   slots_m1_i,
  output mode_e                      mode_o,
  output logic [$clog2(SLOTS):0]     cnt_o
);
  localparam int unsigned SLOT_W = $clog2(SLOTS);
  localparam int unsigned CNT_W  = SLOT_W + 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_o <= MODE_RING;
      cnt_o  <= CNT_W'(1);
    end else if (load_i) begin
      mode_o <= seg_i ? MODE_SEG : MODE_RING;
      cnt_o  <= seg_i ? ({1'b0, slots_m1_i} + CNT_W'(1)) : CNT_W'(1);
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ($stable(mode_o) && $stable(cnt_o))); // R9
endmodule

// File: rtl/amw_slot_tracker.sv
module amw_slot_tracker
  import amw_pkg::*;
#(
  parameter int unsigned SLOTS = DEF_SLOTS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      frz_i,
  input  logic [$clog2(SLOTS)-1:0]  frz_idx_i,
  input  logic                      rel_i,
  input  logic [$clog2(SLOTS)-1:0]  rel_idx_i,
  output logic [SLOTS-1:0]          frozen_o,
  output logic [SLOTS-1:0]          frozen_nxt_o
);
  always_comb begin
    frozen_nxt_o = frozen_o;
    if (frz_i) frozen_nxt_o[frz_idx_i] = 1'b1;
    if (rel_i) frozen_nxt_o[rel_idx_i] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frozen_o <= '0;
    else        frozen_o <= frozen_nxt_o;
  end

  AST_FREEZE_OPEN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    frz_i |-> !frozen_o[frz_idx_i]); // R6
  AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rel_i |=> !frozen_o[$past(rel_idx_i)]); // R8
endmodule

// File: rtl/amw_cell_decoder.sv
module amw_cell_decoder
  import amw_pkg::*;
#(
  parameter int unsigned CELLS = DEF_CELLS
) (
  input  logic                      en_i,
  input  logic [$clog2(CELLS)-1:0]  idx_i,
  output logic [CELLS-1:0]          we_o
);
  localparam int unsigned PTR_W = $clog2(CELLS);

  for (genvar g = 0; g < CELLS; g++) begin : g_cell
    assign we_o[g] = en_i && (idx_i == PTR_W'(g));
  end
endmodule

// File: rtl/amw_write_ctrl.sv
module amw_write_ctrl
  import amw_pkg::*;
#(
  parameter int unsigned CELLS      = DEF_CELLS,
  parameter int unsigned SLOT_CELLS = DEF_SLOT_CELLS,
  parameter int unsigned SLOTS      = DEF_SLOTS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      run_i,
  input  logic                      trig_i,
  input  logic                      cfg_seg_i,
  input  logic [$clog2(SLOTS)-1:0]  cfg_slots_i,
  input  logic                      done_i,
  input  logic [$clog2(SLOTS)-1:0]  done_slot_i,
  output logic [CELLS-1:0]          cell_we_o,
  output logic [SLOTS-1:0]          frozen_o,
  output logic                      conv_req_o,
  output logic [$clog2(SLOTS)-1:0]  conv_slot_o,
  output logic [$clog2(CELLS)-1:0]  trig_cell_o,
  output logic                      overflow_o
);
  localparam int unsigned PTR_W  = $clog2(CELLS);
  localparam int unsigned SLOT_W = $clog2(SLOTS);
  localparam int unsigned CNT_W  = SLOT_W + 1;

  // cell number for a slot and an offset inside it
  function automatic logic [PTR_W-1:0] cell_index(input logic [SLOT_W-1:0] slot,
                                                  input logic [PTR_W-1:0]  off,
                                                  input logic              seg);
    if (seg) return PTR_W'(PTR_W'(slot) * PTR_W'(SLOT_CELLS)) + off;
    return off;
  endfunction

  // first slot not busy, walking upward circularly from 'from' (exclusive)
  function automatic logic [SLOT_W:0] pick_free(input logic [SLOTS-1:0]  busy,
                                                input logic [SLOT_W-1:0] from,
                                                input logic [CNT_W-1:0]  cnt);
    logic [SLOT_W-1:0] cand;
    logic [SLOT_W-1:0] sel;
    logic              hit;
    cand = from;
    sel  = '0;
    hit  = 1'b0;
    for (int k = 0; k < SLOTS; k++) begin
      if (({1'b0, cand} + CNT_W'(1)) >= cnt) cand = '0;
      else                                   cand = cand + SLOT_W'(1);
      if (!hit && !busy[cand]) begin
        hit = 1'b1;
        sel = cand;
      end
    end
    return {hit, sel};
  endfunction

  // configuration
  mode_e             mode_q;
  logic [CNT_W-1:0]  cnt_q;

  amw_cfg_latch #(.SLOTS(SLOTS)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (!run_i),
    .seg_i      (cfg_seg_i),
    .slots_m1_i (cfg_slots_i),
    .mode_o     (mode_q),
    .cnt_o      (cnt_q)
  );

  // sequencing state
  logic              wait_q;   // no slot open for writing
  logic              fresh_q;  // waiting since idle: search starts from slot 0
  logic              ovf_q;
  logic [SLOT_W-1:0] act_q;
  logic [PTR_W-1:0]  off_q;
  logic              conv_q;
  logic [SLOT_W-1:0] cslot_q;
  logic [PTR_W-1:0]  tcell_q;

  // named internal events
  logic              seg_mode;
  logic [PTR_W-1:0]  last_off;
  logic              writing;
  logic              trig_hit;
  logic [PTR_W-1:0]  cur_cell;
  logic [SLOT_W-1:0] search_from;
  logic [SLOT_W:0]   pick;
  logic              pick_ok;
  logic [SLOT_W-1:0] pick_slot;
  logic [SLOTS-1:0]  frozen_nxt;

  assign seg_mode    = (mode_q == MODE_SEG);
  assign last_off    = seg_mode ? PTR_W'(SLOT_CELLS - 1) : PTR_W'(CELLS - 1);
  assign writing     = run_i && !wait_q;
  assign trig_hit    = writing && trig_i;
  assign cur_cell    = cell_index(act_q, off_q, seg_mode);
  assign search_from = (wait_q && fresh_q) ? SLOT_W'(cnt_q - CNT_W'(1)) : act_q;
  assign pick        = pick_free(frozen_nxt, search_from, cnt_q);
  assign pick_ok     = pick[SLOT_W];
  assign pick_slot   = pick[SLOT_W-1:0];

  amw_slot_tracker #(.SLOTS(SLOTS)) u_slots (
    .clk          (clk),
    .rst_n        (rst_n),
    .frz_i        (trig_hit),
    .frz_idx_i    (act_q),
    .rel_i        (done_i),
    .rel_idx_i    (done_slot_i),
    .frozen_o     (frozen_o),
    .frozen_nxt_o (frozen_nxt)
  );

  amw_cell_decoder #(.CELLS(CELLS)) u_dec (
    .en_i  (writing),
    .idx_i (cur_cell),
    .we_o  (cell_we_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q  <= 1'b1;
      fresh_q <= 1'b1;
      ovf_q   <= 1'b0;
      act_q   <= '0;
      off_q   <= '0;
      conv_q  <= 1'b0;
      cslot_q <= '0;
      tcell_q <= '0;
    end else begin
      conv_q <= trig_hit;
      if (trig_hit) begin
        cslot_q <= act_q;
        tcell_q <= cur_cell;
      end
      if (!run_i) begin
        wait_q  <= 1'b1;
        fresh_q <= 1'b1;
        ovf_q   <= 1'b0;
        off_q   <= '0;
      end else if (wait_q) begin
        if (pick_ok) begin
          act_q   <= pick_slot;
          off_q   <= '0;
          wait_q  <= 1'b0;
          fresh_q <= 1'b0;
          ovf_q   <= 1'b0;
        end else begin
          ovf_q   <= 1'b1;
        end
      end else if (trig_i) begin
        if (pick_ok) begin
          act_q <= pick_slot;
          off_q <= '0;
        end else begin
          wait_q <= 1'b1;
          ovf_q  <= 1'b1;
        end
      end else begin
        off_q <= (off_q == last_off) ? '0 : off_q + PTR_W'(1);
      end
    end
  end

  assign conv_req_o  = conv_q;
  assign conv_slot_o = cslot_q;
  assign trig_cell_o = tcell_q;
  assign overflow_o  = ovf_q;

  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cell_we_o)); // R2
  AST_WRITE_WHEN_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    writing |-> ($countones(cell_we_o) == 1)); // R2
  AST_OFFSET_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    off_q <= last_off); // R4
  AST_CONV_SLOT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req_o |-> frozen_o[conv_slot_o]); // R5
  AST_WRITE_UNFROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    writing |-> !frozen_o[act_q]); // R6
  AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |-> (cell_we_o == '0)); // R7
  AST_RING_SLOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req_o && !seg_mode) |-> (conv_slot_o == '0)); // R10
endmodule

// File: tb/amw_write_ctrl_test.sv
module amw_write_ctrl_test;
  localparam int CELLS = 256;
  localparam int SC    = 32;
  localparam int NS    = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             run_i = 1'b0;
  logic             trig_i = 1'b0;
  logic             cfg_seg_i = 1'b0;
  logic [2:0]       cfg_slots_i = '0;
  logic             done_i = 1'b0;
  logic [2:0]       done_slot_i = '0;
  logic [CELLS-1:0] cell_we_o;
  logic [NS-1:0]    frozen_o;
  logic             conv_req_o;
  logic [2:0]       conv_slot_o;
  logic [7:0]       trig_cell_o;
  logic             overflow_o;

  amw_write_ctrl uut (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .trig_i(trig_i),
    .cfg_seg_i(cfg_seg_i), .cfg_slots_i(cfg_slots_i),
    .done_i(done_i), .done_slot_i(done_slot_i),
    .cell_we_o(cell_we_o), .frozen_o(frozen_o), .conv_req_o(conv_req_o),
    .conv_slot_o(conv_slot_o), .trig_cell_o(trig_cell_o), .overflow_o(overflow_o)
  );

  always #10 clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  string ph = "R1 reset";

  // bench model of the requirements
  int mw = 1, mf = 1, mo = 0, ma = 0, moff = 0, mfz = 0;
  int mseg = 0, mcnt = 1, mconv = 0, mcs = 0, mtc = 0;

  task automatic check(string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: %s got %0d expected %0d", ph, what, got, exp);
    end
  endtask

  function automatic int we_index();
    int n = 0;
    int at = -1;
    for (int i = 0; i < CELLS; i++) if (cell_we_o[i]) begin n++; at = i; end
    if (n > 1) return -2;
    return at;
  endfunction

  function automatic int m_cell();
    return mseg ? (ma * SC + moff) : moff;
  endfunction

  function automatic int m_free(int busy, int from);
    for (int k = 1; k <= mcnt; k++) begin
      int c = (from + k) % mcnt;
      if (((busy >> c) & 1) == 0) return c;
    end
    return -1;
  endfunction

  task automatic step(bit run, bit trig, bit seg, int sl, bit dn, int ds);
    int rel;
    int nf;
    run_i = run; trig_i = trig; cfg_seg_i = seg; cfg_slots_i = 3'(sl);
    done_i = dn; done_slot_i = 3'(ds);
    #1;
    check((run && !mw) ? (mseg ? "R4 written cell" : "R3 written cell") : "R2 no write",
          we_index(), (run && !mw) ? m_cell() : -1);
    @(posedge clk);
    rel = dn ? (1 << ds) : 0;
    mconv = 0;
    if (!run) begin
      mw = 1; mf = 1; moff = 0; mo = 0; mseg = seg; mcnt = seg ? sl + 1 : 1;
      mfz &= ~rel;
    end else if (mw) begin
      mfz &= ~rel;
      nf = m_free(mfz, mf ? mcnt - 1 : ma);
      if (nf >= 0) begin ma = nf; moff = 0; mw = 0; mf = 0; mo = 0; end
      else mo = 1;
    end else if (trig) begin
      mconv = 1; mcs = ma; mtc = m_cell();
      mfz = (mfz | (1 << ma)) & ~rel;
      nf = m_free(mfz, ma);
      if (nf >= 0) begin ma = nf; moff = 0; end
      else begin mw = 1; mo = 1; end
    end else begin
      moff = (moff + 1) % (mseg ? SC : CELLS);
      mfz &= ~rel;
    end
    @(negedge clk);
    check("R5 conv_req", int'(conv_req_o), mconv);
    if (mconv) begin
      check("R5 conv_slot", int'(conv_slot_o), mcs);
      check("R5 trig_cell", int'(trig_cell_o), mtc);
    end
    check("R8 frozen flags", int'(frozen_o), mfz);
    check("R7 overflow", int'(overflow_o), mo);
  endtask

  task automatic idle_clear(bit seg, int sl);
    for (int s = 0; s < NS; s++) step(0, 0, seg, sl, 1, s);
  endtask

  initial begin
    #4_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1: reset values
    check("R1 no write", we_index(), -1);
    check("R1 frozen", int'(frozen_o), 0);
    check("R1 conv_req", int'(conv_req_o), 0);
    check("R1 overflow", int'(overflow_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // ring layout: full wrap
    ph = "R3 ring wrap";
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 300; i++) step(1, 0, 0, 0, 0, 0);

    // ring trigger halts until slot 0 returns
    ph = "R10 ring trigger";
    step(1, 1, 0, 0, 0, 0);
    ph = "R7 ring halt ignores triggers";
    for (int i = 0; i < 5; i++) step(1, i % 2, 0, 0, 0, 0);
    ph = "R10 ring resume at cell 0";
    step(1, 0, 0, 0, 1, 0);
    for (int i = 0; i < 6; i++) step(1, 0, 0, 0, 0, 0);

    // slotted layout for every slot count
    for (int n = 1; n <= NS; n++) begin
      ph = $sformatf("R4 slotted n=%0d", n);
      idle_clear(1, n - 1);
      for (int i = 0; i < 40; i++) step(1, 0, 1, n - 1, 0, 0);
      ph = $sformatf("R6 next free n=%0d", n);
      for (int t = 0; t < n; t++) begin
        step(1, 1, 1, n - 1, 0, 0);
        step(1, 0, 1, n - 1, 0, 0);
        step(1, 0, 1, n - 1, 0, 0);
      end
      ph = $sformatf("R7 halt n=%0d", n);
      for (int i = 0; i < 4; i++) step(1, i % 2, 1, n - 1, 0, 0);
      ph = $sformatf("R8 release n=%0d", n);
      step(1, 0, 1, n - 1, 1, (n > 1) ? 1 : 0);
      for (int i = 0; i < 5; i++) step(1, 0, 1, n - 1, 0, 0);
    end

    // configuration changes during acquisition are ignored
    ph = "R9 config held";
    idle_clear(1, 1);
    for (int i = 0; i < 40; i++) step(1, 0, 0, 7, 0, 0);
    step(1, 1, 0, 7, 0, 0);
    step(1, 0, 1, 6, 0, 0);
    step(1, 1, 1, 6, 0, 0);
    for (int i = 0; i < 3; i++) step(1, 0, 0, 3, 0, 0);

    // run drop keeps frozen flags, restart at lowest free slot
    ph = "R11 run drop";
    step(0, 0, 1, 1, 0, 0);
    step(0, 0, 1, 1, 1, 1);
    for (int i = 0; i < 5; i++) step(1, 0, 1, 1, 0, 0);
    step(0, 0, 1, 3, 0, 0);
    for (int i = 0; i < 4; i++) step(1, 0, 1, 3, 0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule